// File: doc/BRIEF.md
# Bit-Error and Link-Outage Event Logger

This block sits behind a pattern checker in a serial-link test setup and keeps a time-ordered log of everything that went wrong. Each clock it receives a free-running timestamp, one word of error pattern, which is the XOR of the received and the expected data, with a valid flag, and a link-up indication. Any word that shows at least one flipped bit while the link is healthy becomes a bit-error record. The record carries the timestamp and the raw XOR pattern. When the pattern source is a known pseudo-random sequence, software can use these two fields to rebuild the received data offline.

Loss of link is treated as a separate kind of event. While the link is down, error words are ignored. Instead, the block counts the length of the outage and remembers the time at which the link dropped. When the link returns, it writes one link-lost record that holds both values. Both kinds of record share one FIFO. A host drains this FIFO through a show-ahead read port. When the FIFO is full, new records are dropped, and a sticky overflow flag shows that this happened.

Top module: `link_event_logger`

## Requirements
- R1: Each 64-bit record holds the kind code in bits [63:62] (2'b01 bit error, 2'b10 link lost), a 30-bit timestamp in bits [61:32] and a 32-bit payload in bits [31:0].
- R2: A cycle with `err_vld_i` high, a nonzero `err_xor_i`, and the link up both in this cycle and in the previous cycle writes a bit-error record. Its timestamp is that cycle's `ts_i` and its payload is `err_xor_i`. The record is readable one cycle later.
- R3: A word with `err_vld_i` low, or with an all-zero `err_xor_i`, writes no record.
- R4: No bit-error record is written while `link_up_i` is low, nor in the first cycle in which it is high again.
- R5: The first cycle in which `link_up_i` is low captures `ts_i` as the loss timestamp.
- R6: The first cycle in which `link_up_i` is high again writes a link-lost record. Its timestamp is the captured loss timestamp and its payload is the number of cycles in which the link was low.
- R7: The outage length saturates at 2^DUR_W-1 and does not wrap.
- R8: Records leave the FIFO in write order. `rd_data_o` shows the oldest record whenever `empty_o` is low. `rd_en_i` removes that record, and `rd_en_i` has no effect while the FIFO is empty.
- R9: A record that arrives while the FIFO holds FIFO_DEPTH entries at the start of the cycle is dropped, even if a read happens in the same cycle. The drop sets `ovf_o`, which stays set.
- R10: `ovf_clr_i` clears `ovf_o`. If a drop happens in the same cycle, the flag stays set.
- R11: After reset the FIFO is empty, `level_o` is 0, `ovf_o` is low, and the link is taken to have been up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 30 | Free-running timestamp |
| err_vld_i | input | 1 | Error word valid |
| err_xor_i | input | 32 | Received XOR expected data |
| link_up_i | input | 1 | Link established indication |
| rd_en_i | input | 1 | Pop the oldest record |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rd_data_o | output | 64 | Oldest record (show-ahead) |
| empty_o | output | 1 | FIFO holds no record |
| full_o | output | 1 | FIFO holds FIFO_DEPTH records |
| level_o | output | clog2(FIFO_DEPTH)+1 | Number of stored records |
| ovf_o | output | 1 | Sticky record-dropped flag |

## Verification
The bench builds the logger with FIFO_DEPTH = 4 and DUR_W = 4. With a four-entry FIFO, filling, dropping, and the case of a read and a drop in the same cycle are reached after a handful of records. With a 4-bit duration counter, the saturation point of 15 is reached after a 20-cycle outage. The record format keeps its full widths, so the timestamp and payload fields are checked at their real positions. A behavioural model built on a queue runs in parallel and predicts every output on every clock.

// File: rtl/logger_pkg.sv
package logger_pkg;
  localparam int KIND_W = 2;
  localparam int TS_W   = 30;
  localparam int PAY_W  = 32;
  localparam int REC_W  = KIND_W + TS_W + PAY_W;

  typedef enum logic [KIND_W-1:0] {
    REC_NONE     = 2'b00,
    REC_BITERR   = 2'b01,
    REC_LINKLOST = 2'b10
  } rec_kind_e;

  function automatic logic [REC_W-1:0] pack_record(rec_kind_e k,
                                                   logic [TS_W-1:0] ts,
                                                   logic [PAY_W-1:0] pay);
    return {k, ts, pay};
  endfunction
endpackage

// File: rtl/outage_tracker.sv
module outage_tracker
  import logger_pkg::*;
#(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             guard_ok_o,
  output logic             lost_vld_o,
  output logic [TS_W-1:0]  lost_ts_o,
  output logic [DUR_W-1:0] lost_dur_o
);
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  function automatic logic [DUR_W-1:0] sat_inc(logic [DUR_W-1:0] v);
    return (&v) ? v : v + DUR_ONE;
  endfunction

  logic             prev_up_q;
  logic [DUR_W-1:0] dur_q;
  logic [TS_W-1:0]  loss_ts_q;

  // named link events
  logic link_fall, link_stay_down, link_rise;
  assign link_fall      =  prev_up_q & ~link_up_i;
  assign link_stay_down = ~prev_up_q & ~link_up_i;
  assign link_rise      = ~prev_up_q &  link_up_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_up_q <= 1'b1;
      dur_q     <= '0;
      loss_ts_q <= '0;
    end else begin
      prev_up_q <= link_up_i;
      if (link_fall) begin
        loss_ts_q <= ts_i;
        dur_q     <= DUR_ONE;
      end else if (link_stay_down) begin
        dur_q     <= sat_inc(dur_q);
      end
    end
  end

  assign guard_ok_o = prev_up_q & link_up_i;
  assign lost_vld_o = link_rise;
  assign lost_ts_o  = loss_ts_q;
  assign lost_dur_o = dur_q;

  // R6: a loss record only appears with the link up again
  a_r6_rec_needs_up: assert property (@(posedge clk) disable iff (!rst_n)
    lost_vld_o |-> link_up_i);
  // R7: the counter never wraps back to zero during an outage
  a_r7_dur_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    link_stay_down |=> (dur_q != '0));
  // R5: the loss timestamp holds while the link stays down
  a_r5_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    link_stay_down |=> $stable(loss_ts_q));
endmodule

// File: rtl/record_builder.sv
module record_builder
  import logger_pkg::*;
#(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             guard_ok_i,
  input  logic             err_vld_i,
  input  logic [PAY_W-1:0] err_xor_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             lost_vld_i,
  input  logic [TS_W-1:0]  lost_ts_i,
  input  logic [DUR_W-1:0] lost_dur_i,
  output logic             rec_vld_o,
  output logic [REC_W-1:0] rec_o
);
  logic err_hit;
  assign err_hit = guard_ok_i & err_vld_i & (|err_xor_i);

  always_comb begin
    rec_vld_o = err_hit | lost_vld_i;
    if (lost_vld_i) rec_o = pack_record(REC_LINKLOST, lost_ts_i, PAY_W'(lost_dur_i));
    else            rec_o = pack_record(REC_BITERR, ts_i, err_xor_i);
  end

  // R4: the recovery cycle never carries both kinds of event
  a_r4_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_hit, lost_vld_i}));
  // R3: an all-zero pattern never produces a record on its own
  a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (err_xor_i == '0 && !lost_vld_i) |-> !rec_vld_o);
endmodule

// File: rtl/log_fifo.sv
module log_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_vld_i,
  input  logic [W-1:0]             wr_data_i,
  input  logic                     rd_en_i,
  input  logic                     ovf_clr_i,
  output logic [W-1:0]             rd_data_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic [$clog2(DEPTH):0]   level_o,
  output logic                     ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;

  logic push, drop, pop;
  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign push    = wr_vld_i & ~full_o;
  assign drop    = wr_vld_i &  full_o;
  assign pop     = rd_en_i  & ~empty_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr_q == AW'(g)) mem[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= next_ptr(wr_ptr_q);
      if (pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      ovf_q <= drop | (ovf_q & ~ovf_clr_i);
    end
  end

  assign rd_data_o = mem[rd_ptr_q];
  assign level_o   = cnt_q;
  assign ovf_o     = ovf_q;

  // R9: a drop always leaves the flag set
  a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_o);
  // R9: occupancy stays within the storage
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R8: reading an empty FIFO leaves it empty
  a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !wr_vld_i) |=> empty_o);
  // R10: a clear without a drop lowers the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !drop) |=> !ovf_o);
endmodule

// File: rtl/link_event_logger.sv
module link_event_logger
  import logger_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DUR_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TS_W-1:0]              ts_i,
  input  logic                         err_vld_i,
  input  logic [PAY_W-1:0]             err_xor_i,
  input  logic                         link_up_i,
  input  logic                         rd_en_i,
  input  logic                         ovf_clr_i,
  output logic [REC_W-1:0]             rd_data_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(FIFO_DEPTH):0]  level_o,
  output logic                         ovf_o
);
  logic             guard_ok, lost_vld, rec_vld;
  logic [TS_W-1:0]  lost_ts;
  logic [DUR_W-1:0] lost_dur;
  logic [REC_W-1:0] rec;

  outage_tracker #(.DUR_W(DUR_W)) i_track (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .ts_i(ts_i),
    .guard_ok_o(guard_ok), .lost_vld_o(lost_vld),
    .lost_ts_o(lost_ts), .lost_dur_o(lost_dur)
  );

  record_builder #(.DUR_W(DUR_W)) i_build (
    .clk(clk), .rst_n(rst_n), .guard_ok_i(guard_ok), .err_vld_i(err_vld_i),
    .err_xor_i(err_xor_i), .ts_i(ts_i), .lost_vld_i(lost_vld),
    .lost_ts_i(lost_ts), .lost_dur_i(lost_dur),
    .rec_vld_o(rec_vld), .rec_o(rec)
  );

  log_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) i_fifo (
    .clk(clk), .rst_n(rst_n), .wr_vld_i(rec_vld), .wr_data_i(rec),
    .rd_en_i(rd_en_i), .ovf_clr_i(ovf_clr_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .full_o(full_o), .level_o(level_o), .ovf_o(ovf_o)
  );

  // R4: no bit-error record while the link is down
  a_r4_no_err_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up_i && rec_vld) |-> 1'b0);
endmodule

// File: tb/test_link_event_logger.sv
module test_link_event_logger;
  localparam int DEPTH = 4;
  localparam int DUR_W = 4;
  localparam int DMAX  = (1 << DUR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] ts_i = '0;
  logic        err_vld_i = 1'b0;
  logic [31:0] err_xor_i = '0;
  logic        link_up_i = 1'b1;
  logic        rd_en_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic [63:0] rd_data_o;
  logic        empty_o, full_o, ovf_o;
  logic [2:0]  level_o;

  always #10 clk = ~clk;

  link_event_logger #(.FIFO_DEPTH(DEPTH), .DUR_W(DUR_W)) i_link_event_logger (
    .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .err_vld_i(err_vld_i),
    .err_xor_i(err_xor_i), .link_up_i(link_up_i), .rd_en_i(rd_en_i),
    .ovf_clr_i(ovf_clr_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
    .full_o(full_o), .level_o(level_o), .ovf_o(ovf_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [63:0] mq[$];
  bit          m_prev = 1;
  logic [29:0] m_lts = '0;
  int          m_dur = 0;
  bit          m_ovf = 0;
  int          tsv = 1000;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk("R8", "empty", 64'(empty_o), 64'(mq.size() == 0));
    chk("R8", "level", 64'(level_o), 64'(mq.size()));
    chk("R9", "full", 64'(full_o), 64'(mq.size() == DEPTH));
    chk(tag, "ovf", 64'(ovf_o), 64'(m_ovf));
    // R1 layout: kind [63:62], timestamp [61:32], payload [31:0]
    if (mq.size() > 0) chk(tag, "data", rd_data_o, mq[0]);
  endtask

  task automatic cyc(bit up, bit vld, logic [31:0] x, bit rd, bit clr, string tag);
    bit full_start, have, drop;
    logic [63:0] rec;
    link_up_i = up; err_vld_i = vld; err_xor_i = x; rd_en_i = rd;
    ovf_clr_i = clr; ts_i = 30'(tsv);
    full_start = (mq.size() == DEPTH);
    have = 0; rec = '0;
    if (m_prev && !up) begin m_lts = 30'(tsv); m_dur = 1; end
    else if (!m_prev && !up) begin if (m_dur < DMAX) m_dur++; end
    else if (!m_prev && up) begin have = 1; rec = {2'b10, m_lts, 32'(m_dur)}; end
    if (up && m_prev && vld && x != 0) begin have = 1; rec = {2'b01, 30'(tsv), x}; end
    if (rd && mq.size() > 0) void'(mq.pop_front());
    drop = have && full_start;
    if (have && !full_start) mq.push_back(rec);
    m_ovf = drop || (m_ovf && !clr);
    m_prev = up;
    tsv++;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < DEPTH + 1; k++) cyc(1, 0, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    compare("R11");
    cyc(1, 0, 0, 0, 0, "R11");

    // R2: error words on a healthy link, then read back in order (R8)
    cyc(1, 1, 32'h0000_0001, 0, 0, "R2");
    cyc(1, 1, 32'h8000_0400, 0, 0, "R2");
    cyc(1, 1, 32'hFFFF_FFFF, 0, 0, "R2");
    drain("R8");
    // R8: reading while empty changes nothing
    cyc(1, 0, 0, 1, 0, "R8");

    // R3: invalid or zero patterns are quiet
    cyc(1, 1, 32'h0, 0, 0, "R3");
    cyc(1, 0, 32'h1234_5678, 0, 0, "R3");
    cyc(1, 0, 0, 0, 0, "R3");

    // R5/R4: outage of 5 cycles with error words present
    for (int k = 0; k < 5; k++) cyc(0, 1, 32'hDEAD_0000 + 32'(k), 0, 0, "R4");
    // R6/R4: recovery cycle with an error word, then one more counted
    cyc(1, 1, 32'h0000_00F0, 0, 0, "R6");
    cyc(1, 1, 32'h0000_0F00, 0, 0, "R2");
    drain("R6");

    // R7: long outage saturates
    for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R7");
    drain("R7");

    // R5: one-cycle outage
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, "R5");
    drain("R5");

    // R9: fill, overflow, and drop while popping
    for (int k = 0; k < DEPTH; k++) cyc(1, 1, 32'(k + 1), 0, 0, "R9");
    cyc(1, 1, 32'hAAAA_AAAA, 0, 0, "R9");
    cyc(1, 1, 32'h5555_5555, 1, 0, "R9");
    // R10: clear with a concurrent drop keeps the flag
    cyc(1, 1, 32'h7, 0, 0, "R10");
    cyc(1, 1, 32'h9, 0, 1, "R10");
    // R10: plain clear
    cyc(1, 0, 0, 0, 1, "R10");
    cyc(1, 0, 0, 0, 0, "R10");
    drain("R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule